// File: doc/BRIEF.md
# Pipelined Multiplier with Half-Width Result Return

This unit serves one issue slot of a processing cluster. It multiplies two 16-bit operands over two pipelined execute stages and hands the 32-bit product back through a writeback port that is only 16 bits wide. An operation either asks for the low half only, or for the whole product. In the second case the low half is returned first and the high half follows in the next cycle.

A new multiply can be issued on every cycle when only low halves are requested. A full-product request holds the slot for one extra cycle. During that cycle the unit raises a busy flag, and any issue presented then is dropped. Operands are read as two's-complement numbers or as unsigned numbers, chosen for each issue. The result reaches the writeback port one cycle later than it would from a single-cycle operation. The register file and any operand bypassing live outside the unit.

Top module: `split_wb_mul`

## Requirements
- R1: While reset is low, and after reset until the first accepted issue has travelled through the pipe, `wb_vld` and `iss_busy` are 0.
- R2: An issue is accepted when `iss_vld` is 1 and `iss_busy` is 0 at a rising edge. Its low result half appears with `wb_vld`=1, `wb_hi`=0 and `wb_tag` equal to the issue tag in the cycle after the second rising edge that follows the issue.
- R3: With `iss_sgn`=1 the operands are two's-complement values. With `iss_sgn`=0 they are unsigned. `wb_data` carries bits 15:0 of the product on the low-half cycle and bits 31:16 on the high-half cycle.
- R4: With `iss_full`=1 the high half follows in the very next cycle with `wb_hi`=1 and `wb_tag` equal to the issue tag plus one, modulo 2^TAGW (so 31 wraps to 0).
- R5: Low-only issues (`iss_full`=0) are accepted on consecutive cycles with no gap, and none of them produces a high-half cycle.
- R6: `iss_busy` is 1 exactly in the cycle after an accepted full-product issue. An issue presented while `iss_busy` is 1 is dropped and never produces a writeback.
- R7: `wb_vld` is 1 only on the low-half cycle of an accepted issue or on the high-half cycle of an accepted full-product issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Multiply request present |
| iss_a | input | 16 | First operand |
| iss_b | input | 16 | Second operand |
| iss_tag | input | 5 | Destination register tag |
| iss_full | input | 1 | 1: return both halves, 0: low half only |
| iss_sgn | input | 1 | 1: signed operands, 0: unsigned |
| iss_busy | output | 1 | Issue slot blocked this cycle |
| wb_vld | output | 1 | Writeback valid |
| wb_data | output | 16 | Writeback data half |
| wb_tag | output | 5 | Destination tag of this half |
| wb_hi | output | 1 | 1: high product half, 0: low half |

## Verification
The bound checker re-checks on every cycle the fixed latency of both halves and their tags. It also checks the low-half value in both signedness modes, the busy cycle after a full request, and that no writeback appears without an accepted issue. The bench's scenarios are needed for everything else. They show that an issue offered during busy really disappears from the output stream, that high-half values are right at the operand extremes, that the tag wraps from 31 to 0, and that long back-to-back runs of mixed modes keep the output stream in order.

// File: rtl/mulwb_pkg.sv
package mulwb_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic logic [31:0] seg_shift(input int idx, input int segw);
    return 32'(idx * segw);
  endfunction
endpackage

// File: rtl/mulwb_ppgen.sv
// Stage-1 logic: one signed partial product per slice of operand b.
module mulwb_ppgen #(
  parameter int DW   = 16,
  parameter int SEGW = 8,
  parameter int NSEG = DW / SEGW,
  parameter int PPW  = DW + SEGW + 2
) (
  input  logic [DW-1:0]             opa,
  input  logic [DW-1:0]             opb,
  input  logic                      sgn,
  output logic [NSEG-1:0][PPW-1:0]  pp
);
  logic signed [DW:0] a_ext;
  assign a_ext = {sgn & opa[DW-1], opa};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic signed [SEGW:0]  bseg;
    logic signed [PPW-1:0] prod;
    if (g == NSEG - 1) begin : g_top
      // top slice carries the sign of b in signed mode
      assign bseg = {sgn & opb[DW-1], opb[g*SEGW +: SEGW]};
    end else begin : g_low
      assign bseg = {1'b0, opb[g*SEGW +: SEGW]};
    end
    assign prod  = a_ext * bseg;
    assign pp[g] = prod;
  end
endmodule

// File: rtl/mulwb_reduce.sv
// Stage-2 logic: sign-extend, align and sum the partial products.
module mulwb_reduce #(
  parameter int DW   = 16,
  parameter int SEGW = 8,
  parameter int NSEG = DW / SEGW,
  parameter int PPW  = DW + SEGW + 2,
  parameter int PW   = 2 * DW
) (
  input  logic [NSEG-1:0][PPW-1:0] pp,
  output logic [PW-1:0]            prod
);
  import mulwb_pkg::*;

  logic [PW-1:0] acc;
  logic [PW-1:0] ext;

  always_comb begin
    acc = '0;
    ext = '0;
    for (int i = 0; i < NSEG; i++) begin
      ext = {{(PW-PPW){pp[i][PPW-1]}}, pp[i]};
      acc = acc + (ext << seg_shift(i, SEGW));
    end
    prod = acc;
  end
endmodule

// File: rtl/mulwb_wbsel.sv
// Chooses between a fresh low half and a parked high half.
module mulwb_wbsel #(
  parameter int DW   = 16,
  parameter int TAGW = 5
) (
  input  logic            lo_vld,
  input  logic [DW-1:0]   lo_data,
  input  logic [TAGW-1:0] lo_tag,
  input  logic            hi_vld,
  input  logic [DW-1:0]   hi_data,
  input  logic [TAGW-1:0] hi_tag,
  output logic            out_vld,
  output logic [DW-1:0]   out_data,
  output logic [TAGW-1:0] out_tag,
  output logic            out_hi
);
  import mulwb_pkg::*;

  half_e sel;

  always_comb begin
    sel      = hi_vld ? HALF_HI : HALF_LO;
    out_vld  = lo_vld | hi_vld;
    out_hi   = (sel == HALF_HI);
    out_data = (sel == HALF_HI) ? hi_data : lo_data;
    out_tag  = (sel == HALF_HI) ? hi_tag  : lo_tag;
  end
endmodule

// File: rtl/split_wb_mul.sv
module split_wb_mul #(
  parameter int DW   = 16,
  parameter int TAGW = 5,
  parameter int SEGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic [DW-1:0]   iss_a,
  input  logic [DW-1:0]   iss_b,
  input  logic [TAGW-1:0] iss_tag,
  input  logic            iss_full,
  input  logic            iss_sgn,
  output logic            iss_busy,
  output logic            wb_vld,
  output logic [DW-1:0]   wb_data,
  output logic [TAGW-1:0] wb_tag,
  output logic            wb_hi
);
  localparam int NSEG = DW / SEGW;
  localparam int PPW  = DW + SEGW + 2;
  localparam int PW   = 2 * DW;

  // stage 1: partial products
  logic                     s1_vld, s1_vld_d;
  logic                     s1_full, s1_full_d;
  logic [TAGW-1:0]          s1_tag, s1_tag_d;
  logic [NSEG-1:0][PPW-1:0] s1_pp, s1_pp_d;
  logic                     s1_en;
  // stage 2: full product
  logic                     s2_vld, s2_vld_d;
  logic                     s2_full, s2_full_d;
  logic [TAGW-1:0]          s2_tag, s2_tag_d;
  logic [PW-1:0]            s2_prod, s2_prod_d;
  logic                     s2_en;
  // parked high half
  logic                     hp_vld, hp_vld_d;
  logic [TAGW-1:0]          hp_tag, hp_tag_d;
  logic [DW-1:0]            hp_data, hp_data_d;
  logic                     hp_en;

  logic                     accept;
  logic [PW-1:0]            sum;

  mulwb_ppgen #(.DW(DW), .SEGW(SEGW), .NSEG(NSEG), .PPW(PPW)) u_ppgen (
    .opa (iss_a),
    .opb (iss_b),
    .sgn (iss_sgn),
    .pp  (s1_pp_d)
  );

  mulwb_reduce #(.DW(DW), .SEGW(SEGW), .NSEG(NSEG), .PPW(PPW), .PW(PW)) u_reduce (
    .pp   (s1_pp),
    .prod (sum)
  );

  // next-state logic
  always_comb begin
    iss_busy  = s1_vld & s1_full;
    accept    = iss_vld & ~iss_busy;

    s1_en     = accept;
    s1_vld_d  = accept;
    s1_full_d = iss_full;
    s1_tag_d  = iss_tag;

    s2_en     = s1_vld;
    s2_vld_d  = s1_vld;
    s2_full_d = s1_full;
    s2_tag_d  = s1_tag;
    s2_prod_d = sum;

    hp_en     = s2_vld & s2_full;
    hp_vld_d  = s2_vld & s2_full;
    hp_tag_d  = s2_tag + TAGW'(1);
    hp_data_d = s2_prod[PW-1:DW];
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      hp_vld <= 1'b0;
    end else begin
      s1_vld <= s1_vld_d;
      s2_vld <= s2_vld_d;
      hp_vld <= hp_vld_d;
    end
  end

  // datapath registers
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_full <= s1_full_d;
      s1_tag  <= s1_tag_d;
      s1_pp   <= s1_pp_d;
    end
    if (s2_en) begin
      s2_full <= s2_full_d;
      s2_tag  <= s2_tag_d;
      s2_prod <= s2_prod_d;
    end
    if (hp_en) begin
      hp_tag  <= hp_tag_d;
      hp_data <= hp_data_d;
    end
  end

  mulwb_wbsel #(.DW(DW), .TAGW(TAGW)) u_wbsel (
    .lo_vld   (s2_vld),
    .lo_data  (s2_prod[DW-1:0]),
    .lo_tag   (s2_tag),
    .hi_vld   (hp_vld),
    .hi_data  (hp_data),
    .hi_tag   (hp_tag),
    .out_vld  (wb_vld),
    .out_data (wb_data),
    .out_tag  (wb_tag),
    .out_hi   (wb_hi)
  );
endmodule

// File: rtl/mulwb_chk.sv
module mulwb_chk #(
  parameter int DW   = 16,
  parameter int TAGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_vld,
  input logic [DW-1:0]   iss_a,
  input logic [DW-1:0]   iss_b,
  input logic [TAGW-1:0] iss_tag,
  input logic            iss_full,
  input logic            iss_sgn,
  input logic            iss_busy,
  input logic            wb_vld,
  input logic [DW-1:0]   wb_data,
  input logic [TAGW-1:0] wb_tag,
  input logic            wb_hi
);
  function automatic logic [2*DW-1:0] refp(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic s);
    logic [2*DW-1:0] ea, eb;
    ea = s ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
    eb = s ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};
    return ea * eb;
  endfunction

  logic acc;
  assign acc = iss_vld & ~iss_busy;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!wb_vld && !iss_busy)); // R1

  AST_LOW_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 (wb_vld && !wb_hi && wb_tag == $past(iss_tag, 2))); // R2

  AST_LOW_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 (wb_data == refp($past(iss_a, 2), $past(iss_b, 2), $past(iss_sgn, 2))[DW-1:0])); // R3

  AST_HIGH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && iss_full) |=> ##2 (wb_vld && wb_hi && wb_tag == TAGW'($past(iss_tag, 3) + 1'b1))); // R4

  AST_LOW_ONLY_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !iss_full) |=> ##2 !(wb_vld && wb_hi)); // R5

  AST_BUSY_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && iss_full) |=> iss_busy); // R6

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_busy |-> $past(acc && iss_full)); // R6

  AST_WB_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> ($past(acc, 2) || $past(acc && iss_full, 3))); // R7
endmodule

bind split_wb_mul mulwb_chk #(.DW(DW), .TAGW(TAGW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_vld  (iss_vld),
  .iss_a    (iss_a),
  .iss_b    (iss_b),
  .iss_tag  (iss_tag),
  .iss_full (iss_full),
  .iss_sgn  (iss_sgn),
  .iss_busy (iss_busy),
  .wb_vld   (wb_vld),
  .wb_data  (wb_data),
  .wb_tag   (wb_tag),
  .wb_hi    (wb_hi)
);

// File: tb/split_wb_mul_test.sv
module split_wb_mul_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int TAGW = 5;
  localparam int NCYC = 3000;

  logic            clk, rst_n;
  logic            iss_vld, iss_full, iss_sgn, iss_busy;
  logic [DW-1:0]   iss_a, iss_b, wb_data;
  logic [TAGW-1:0] iss_tag, wb_tag;
  logic            wb_vld, wb_hi;

  split_wb_mul uut (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_a(iss_a), .iss_b(iss_b),
    .iss_tag(iss_tag), .iss_full(iss_full), .iss_sgn(iss_sgn), .iss_busy(iss_busy),
    .wb_vld(wb_vld), .wb_data(wb_data), .wb_tag(wb_tag), .wb_hi(wb_hi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            ev [0:NCYC+4];
  logic [DW-1:0]   ed [0:NCYC+4];
  logic [TAGW-1:0] et [0:NCYC+4];
  logic            eh [0:NCYC+4];
  int n_chk = 0;
  int n_fail = 0;

  function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b,
                                           input logic s);
    logic signed [31:0] sa, sb;
    if (s) begin
      sa = {{16{a[15]}}, a};
      sb = {{16{b[15]}}, b};
      return 32'(sa * sb);
    end
    return {16'd0, a} * {16'd0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic busy_m, v, f, s, acc;
    logic [DW-1:0] a, b;
    logic [TAGW-1:0] tg;
    logic [31:0] p;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i <= NCYC + 4; i++) begin
      ev[i] = 1'b0; ed[i] = '0; et[i] = '0; eh[i] = 1'b0;
    end
    rst_n = 1'b0; iss_vld = 1'b0; iss_a = '0; iss_b = '0;
    iss_tag = '0; iss_full = 1'b0; iss_sgn = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wb_vld && !iss_busy, "R1 outputs in reset", {wb_vld, iss_busy}, 0);
    rst_n = 1'b1;
    busy_m = 1'b0;
    for (int t = 0; t < NCYC; t++) begin
      // R7 valid stream, R2/R3/R4 contents, R6 busy
      chk(wb_vld == ev[t], "R7 wb_vld", wb_vld, ev[t]);
      if (ev[t] && wb_vld) begin
        chk(wb_data == ed[t], eh[t] ? "R4 R3 high data" : "R2 R3 low data", wb_data, ed[t]);
        chk(wb_tag == et[t], eh[t] ? "R4 high tag" : "R2 low tag", wb_tag, et[t]);
        chk(wb_hi == eh[t], "R4 half flag", wb_hi, eh[t]);
      end
      chk(iss_busy == busy_m, "R6 busy", iss_busy, busy_m);
      v = 1'b0; f = 1'b0; s = 1'b0; a = '0; b = '0; tg = '0;
      case (t)
        3:  begin v = 1; f = 1; s = 1; a = 16'h8000; b = 16'h8000; tg = 5'd3; end
        4:  begin v = 1; f = 0; s = 0; a = 16'd7; b = 16'd7; tg = 5'd9; end   // R6 dropped
        5:  begin v = 1; f = 0; s = 0; a = 16'hFFFF; b = 16'hFFFF; tg = 5'd5; end // R5 run
        6:  begin v = 1; f = 0; s = 1; a = 16'hFFFF; b = 16'hFFFF; tg = 5'd6; end
        7:  begin v = 1; f = 0; s = 1; a = 16'h7FFF; b = 16'h8000; tg = 5'd7; end
        8:  begin v = 1; f = 0; s = 0; a = 16'd1234; b = 16'd5678; tg = 5'd8; end
        9:  begin v = 1; f = 1; s = 0; a = 16'hFFFF; b = 16'hFFFF; tg = 5'd31; end // R4 wrap
        11: begin v = 1; f = 1; s = 1; a = 16'hFFFD; b = 16'd5; tg = 5'd12; end
        13: begin v = 1; f = 1; s = 1; a = 16'h8000; b = 16'h7FFF; tg = 5'd20; end
        14: begin v = 1; f = 1; s = 0; a = 16'h1111; b = 16'h2222; tg = 5'd21; end // R6 dropped
        default: begin
          if (t >= 20 && t < NCYC - 5) begin
            v  = ($urandom % 4) != 0;
            f  = $urandom % 2;
            s  = $urandom % 2;
            a  = (($urandom % 8) == 0) ? 16'h8000 : 16'($urandom);
            b  = (($urandom % 8) == 0) ? 16'hFFFF : 16'($urandom);
            tg = TAGW'($urandom);
          end
        end
      endcase
      acc = v && !busy_m;
      if (acc) begin
        p = ref_prod(a, b, s);
        ev[t+2] = 1'b1; ed[t+2] = p[15:0]; et[t+2] = tg; eh[t+2] = 1'b0;
        if (f) begin
          ev[t+3] = 1'b1; ed[t+3] = p[31:16]; et[t+3] = TAGW'(tg + 1'b1); eh[t+3] = 1'b1;
        end
      end
      busy_m = acc && f;
      iss_vld = v; iss_full = f; iss_sgn = s; iss_a = a; iss_b = b; iss_tag = tg;
      @(negedge clk);
    end
    finish_run();
  end
endmodule